// File: doc/BRIEF.md
# Half-Step Stepper Current Sequencer

This block drives the control inputs of two H-bridges that share a bipolar stepper motor. It tracks an electrical position in the range 0 to 7. For each position it emits a polarity bit and a 2-bit current-level code for each bridge. The code sets the winding current so that torque stays the same whether one winding or both are energized. Each step pulse moves the position one place forward or backward. In full-step mode the sequencer uses only the positions where both windings are energized.

A winding's polarity can only change while that winding's bridge is switched fully off. When a step would flip the polarity of an energized winding, the sequencer first forces that bridge to the off code. It holds the off code for a programmable number of clock cycles so that the winding current can decay quickly. Only after that does it apply the new polarity and position. While this interval runs, a busy flag is high and further step pulses are ignored. A hold request lowers the current of the energized windings, and a start-up request raises it to full.

Top module: `hstep_seq`

## Requirements
- R1: During reset and after it, the outputs show position 0: both polarity bits 1, both current codes 2'b01, and busy 0.
- R2: In half-step mode the eight positions are as follows. Winding A is positive at positions 0, 1 and 2, off at 3, negative at 4, 5 and 6, and off at 7. Winding B is positive at 7, 0 and 6, off at 1, negative at 2, 3 and 4, and off at 5. Polarity bit 1 means positive. Direction 1 increments the position and direction 0 decrements it.
- R3: Current codes are {sel1, sel0}, where 2'b00 is full, 2'b01 is two-thirds, 2'b10 is one-third and 2'b11 is off. With no hold or boost request, a winding that is energized alone gets 2'b00. When both windings are energized, each gets 2'b01. A winding that is not energized gets 2'b11.
- R4: While hold is high, every energized winding gets 2'b10. While boost is high, every energized winding gets 2'b00, and boost takes priority over hold. A change in these inputs takes effect at the next clock edge, with or without a step.
- R5: A step that would give an energized winding a polarity different from its present polarity bit starts a decay interval.
  - During the interval that bridge shows 2'b11 and keeps its old polarity.
  - The other bridge keeps the code of the present position.
  - busy is high for exactly decay_len_i cycles, where a value of 0 counts as 1.
  - At the end of the interval the new position and polarity are applied together.
- R6: A step pulse sampled while busy is high has no effect on the position.
- R7: In full-step mode a step moves to the next even position in the chosen direction. From an odd position this is the neighbouring even position. From an even position it is two places away.
- R8: The position wraps modulo 8 in both directions.
- R9: A winding that is not energized keeps its last polarity bit.
- R10: A step that reverses no winding updates the outputs at the next clock edge, and busy stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step_i | input | 1 | Step request, sampled on each clock edge |
| dir_i | input | 1 | 1 = increasing position, 0 = decreasing |
| half_i | input | 1 | 1 = half-step mode, 0 = full-step mode |
| hold_i | input | 1 | Reduced-current request |
| boost_i | input | 1 | Full-current request, has priority over hold |
| decay_len_i | input | DLY_W | Length of the decay interval in cycles (0 acts as 1) |
| phase_a_o | output | 1 | Polarity of bridge A |
| cur_a_o | output | 2 | Current code of bridge A |
| phase_b_o | output | 1 | Polarity of bridge B |
| cur_b_o | output | 2 | Current code of bridge B |
| busy_o | output | 1 | High during a decay interval |

## Verification
The level assertions assume that hold and boost are low while reset is asserted. They also judge each current code against the hold and boost values sampled on the edge that produced that code. The polarity assertions assume that reset starts from position 0 with both polarities at 1.

The bench keeps to these assumptions. It changes every input only at falling clock edges, holds every request low during reset, and keeps decay_len_i within a few cycles so that many reversals occur. Its random phase mixes step, direction, mode, hold and boost freely, including steps pulsed during decay intervals.

// File: rtl/hstep_pkg.sv
package hstep_pkg;
    localparam int POS_W = 3;
    localparam int NBRIDGE = 2;

    typedef logic [1:0] lvl_t;
    localparam lvl_t LVL_FULL = 2'b00;
    localparam lvl_t LVL_TWO3 = 2'b01;
    localparam lvl_t LVL_ONE3 = 2'b10;
    localparam lvl_t LVL_OFF  = 2'b11;

    typedef struct packed {
        logic on;
        logic pol;
    } wind_t;
endpackage

// File: rtl/hstep_decode.sv
module hstep_decode
    import hstep_pkg::*;
(
    input  logic [POS_W-1:0] pos_i,
    output wind_t            wa_o,
    output wind_t            wb_o
);
    // Winding A is off at 3 and 7, winding B at 1 and 5.
    always_comb begin
        wa_o.on  = (pos_i[1:0] != 2'b11);
        wa_o.pol = (pos_i <= POS_W'(2));
        wb_o.on  = (pos_i[1:0] != 2'b01);
        wb_o.pol = (pos_i == '0) || (pos_i >= POS_W'(6));
    end
endmodule

// File: rtl/hstep_next.sv
module hstep_next
    import hstep_pkg::*;
(
    input  logic [POS_W-1:0] pos_i,
    input  logic             dir_i,
    input  logic             half_i,
    output logic [POS_W-1:0] tgt_o
);
    always_comb begin
        if (half_i) begin
            tgt_o = dir_i ? pos_i + POS_W'(1) : pos_i - POS_W'(1);
        end else if (dir_i) begin
            tgt_o = (pos_i | POS_W'(1)) + POS_W'(1);
        end else begin
            tgt_o = (pos_i - POS_W'(1)) & ~POS_W'(1);
        end
    end
endmodule

// File: rtl/hstep_level.sv
module hstep_level
    import hstep_pkg::*;
(
    input  logic on_i,
    input  logic other_on_i,
    input  logic mask_i,
    input  logic hold_i,
    input  logic boost_i,
    output lvl_t lvl_o
);
    always_comb begin
        if (!on_i || mask_i) begin
            lvl_o = LVL_OFF;
        end else if (boost_i) begin
            lvl_o = LVL_FULL;
        end else if (hold_i) begin
            lvl_o = LVL_ONE3;
        end else if (other_on_i) begin
            lvl_o = LVL_TWO3;
        end else begin
            lvl_o = LVL_FULL;
        end
    end
endmodule

// File: rtl/hstep_seq.sv
module hstep_seq
    import hstep_pkg::*;
#(
    parameter int DLY_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_i,
    input  logic             dir_i,
    input  logic             half_i,
    input  logic             hold_i,
    input  logic             boost_i,
    input  logic [DLY_W-1:0] decay_len_i,
    output logic             phase_a_o,
    output logic [1:0]       cur_a_o,
    output logic             phase_b_o,
    output logic [1:0]       cur_b_o,
    output logic             busy_o
);
    typedef struct packed {
        logic [POS_W-1:0]   pos;
        logic [NBRIDGE-1:0] ph;
        logic               busy;
        logic [DLY_W-1:0]   cnt;
        logic [POS_W-1:0]   pend;
        logic [NBRIDGE-1:0] mask;
    } st_t;

    st_t st_d, st_q;
    lvl_t lvl_d [NBRIDGE];
    lvl_t lvl_q [NBRIDGE];

    logic [POS_W-1:0] tgt_pos;
    wind_t wt_a, wt_b, wp_a, wp_b, wd_a, wd_b;
    wind_t wt [NBRIDGE];
    wind_t wp [NBRIDGE];
    logic [NBRIDGE-1:0] wd_on;
    logic [NBRIDGE-1:0] rev;

    hstep_next next_i (
        .pos_i (st_q.pos),
        .dir_i (dir_i),
        .half_i(half_i),
        .tgt_o (tgt_pos)
    );

    hstep_decode dec_tgt_i  (.pos_i(tgt_pos),   .wa_o(wt_a), .wb_o(wt_b));
    hstep_decode dec_pend_i (.pos_i(st_q.pend), .wa_o(wp_a), .wb_o(wp_b));
    hstep_decode dec_next_i (.pos_i(st_d.pos),  .wa_o(wd_a), .wb_o(wd_b));

    always_comb begin
        wt[0] = wt_a;
        wt[1] = wt_b;
        wp[0] = wp_a;
        wp[1] = wp_b;
        wd_on = {wd_b.on, wd_a.on};
        for (int i = 0; i < NBRIDGE; i++) begin
            rev[i] = wt[i].on && (wt[i].pol != st_q.ph[i]);
        end
    end

    // Next-state computation.
    always_comb begin
        st_d = st_q;
        if (st_q.busy) begin
            if (st_q.cnt == '0) begin
                st_d.pos  = st_q.pend;
                st_d.busy = 1'b0;
                st_d.mask = '0;
                for (int i = 0; i < NBRIDGE; i++) begin
                    st_d.ph[i] = wp[i].on ? wp[i].pol : st_q.ph[i];
                end
            end else begin
                st_d.cnt = st_q.cnt - DLY_W'(1);
            end
        end else if (step_i) begin
            if (rev != '0) begin
                st_d.busy = 1'b1;
                st_d.cnt  = (decay_len_i == '0) ? '0 : decay_len_i - DLY_W'(1);
                st_d.pend = tgt_pos;
                st_d.mask = rev;
            end else begin
                st_d.pos = tgt_pos;
                for (int i = 0; i < NBRIDGE; i++) begin
                    st_d.ph[i] = wt[i].on ? wt[i].pol : st_q.ph[i];
                end
            end
        end
    end

    for (genvar g = 0; g < NBRIDGE; g++) begin : g_lvl
        hstep_level level_i (
            .on_i      (wd_on[g]),
            .other_on_i(wd_on[NBRIDGE-1-g]),
            .mask_i    (st_d.mask[g]),
            .hold_i    (hold_i),
            .boost_i   (boost_i),
            .lvl_o     (lvl_d[g])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.pos  <= '0;
            st_q.ph   <= '1;
            st_q.busy <= 1'b0;
            st_q.cnt  <= '0;
            st_q.pend <= '0;
            st_q.mask <= '0;
            for (int i = 0; i < NBRIDGE; i++) begin
                lvl_q[i] <= LVL_TWO3;
            end
        end else begin
            st_q <= st_d;
            for (int i = 0; i < NBRIDGE; i++) begin
                lvl_q[i] <= lvl_d[i];
            end
        end
    end

    assign phase_a_o = st_q.ph[0];
    assign phase_b_o = st_q.ph[1];
    assign cur_a_o   = lvl_q[0];
    assign cur_b_o   = lvl_q[1];
    assign busy_o    = st_q.busy;
endmodule

// File: rtl/hstep_seq_chk.sv
module hstep_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       hold_i,
    input logic       boost_i,
    input logic       phase_a_o,
    input logic [1:0] cur_a_o,
    input logic       phase_b_o,
    input logic [1:0] cur_b_o,
    input logic       busy_o
);
    logic seen_q;
    always_ff @(posedge clk) begin
        if (!rst_n) seen_q <= 1'b0;
        else        seen_q <= 1'b1;
    end

    assert_both_not_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(cur_a_o == 2'b11 && cur_b_o == 2'b11));

    assert_two3_pair_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_a_o == 2'b01 && !busy_o) |-> (cur_b_o != 2'b11));

    assert_one3_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && (cur_a_o == 2'b10 || cur_b_o == 2'b10)) |-> ($past(hold_i) && !$past(boost_i)));

    assert_two3_no_request_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && (cur_a_o == 2'b01 || cur_b_o == 2'b01)) |-> (!$past(hold_i) && !$past(boost_i)));

    assert_flip_a_after_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_a_o != $past(phase_a_o)) |-> ($past(cur_a_o) == 2'b11 && $fell(busy_o)));

    assert_flip_b_after_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_b_o != $past(phase_b_o)) |-> ($past(cur_b_o) == 2'b11 && $fell(busy_o)));

    assert_busy_ends_with_flip_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> ((phase_a_o != $past(phase_a_o)) || (phase_b_o != $past(phase_b_o))));
endmodule

bind hstep_seq hstep_seq_chk chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .hold_i   (hold_i),
    .boost_i  (boost_i),
    .phase_a_o(phase_a_o),
    .cur_a_o  (cur_a_o),
    .phase_b_o(phase_b_o),
    .cur_b_o  (cur_b_o),
    .busy_o   (busy_o)
);

// File: tb/hstep_seq_tb_top.sv
module hstep_seq_tb_top;
    localparam int DLY_W = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic step_i = 1'b0, dir_i = 1'b1, half_i = 1'b1, hold_i = 1'b0, boost_i = 1'b0;
    logic [DLY_W-1:0] decay_len_i = '0;
    logic phase_a_o, phase_b_o, busy_o;
    logic [1:0] cur_a_o, cur_b_o;

    always #2 clk = ~clk;

    hstep_seq #(.DLY_W(DLY_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .step_i(step_i), .dir_i(dir_i), .half_i(half_i),
        .hold_i(hold_i), .boost_i(boost_i), .decay_len_i(decay_len_i),
        .phase_a_o(phase_a_o), .cur_a_o(cur_a_o), .phase_b_o(phase_b_o),
        .cur_b_o(cur_b_o), .busy_o(busy_o)
    );

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    // Reference model state.
    int m_pos, m_pend, m_cnt;
    bit m_busy;
    bit m_ph [2];
    bit m_mask [2];
    logic [1:0] m_cur [2];

    function automatic bit on_w(int b, int p);
        return (b == 0) ? (p % 4 != 3) : (p % 4 != 1);
    endfunction

    function automatic bit pol_w(int b, int p);
        return (b == 0) ? (p <= 2) : (p == 0 || p >= 6);
    endfunction

    function automatic int tgt_of(int p, bit d, bit h);
        if (h) return d ? (p + 1) % 8 : (p + 7) % 8;
        if (d) return ((p | 1) + 1) % 8;
        return ((p + 7) % 8) & 6;
    endfunction

    function automatic logic [1:0] lvl_of(bit on, bit oth, bit mk, bit hd, bit bs);
        if (!on || mk) return 2'b11;
        if (bs) return 2'b00;
        if (hd) return 2'b10;
        return oth ? 2'b01 : 2'b00;
    endfunction

    task automatic model_reset();
        m_pos = 0; m_pend = 0; m_cnt = 0; m_busy = 0;
        for (int b = 0; b < 2; b++) begin
            m_ph[b] = 1; m_mask[b] = 0; m_cur[b] = 2'b01;
        end
    endtask

    task automatic model_edge();
        int t;
        bit rv [2];
        if (m_busy) begin
            if (m_cnt == 0) begin
                m_pos = m_pend;
                for (int b = 0; b < 2; b++) begin
                    if (on_w(b, m_pos)) m_ph[b] = pol_w(b, m_pos);
                    m_mask[b] = 0;
                end
                m_busy = 0;
            end else begin
                m_cnt--;
            end
        end else if (step_i) begin
            t = tgt_of(m_pos, dir_i, half_i);
            for (int b = 0; b < 2; b++) rv[b] = on_w(b, t) && (pol_w(b, t) != m_ph[b]);
            if (rv[0] || rv[1]) begin
                m_busy = 1;
                m_cnt = (decay_len_i == 0) ? 0 : int'(decay_len_i) - 1;
                m_pend = t;
                for (int b = 0; b < 2; b++) m_mask[b] = rv[b];
            end else begin
                m_pos = t;
                for (int b = 0; b < 2; b++) if (on_w(b, t)) m_ph[b] = pol_w(b, t);
            end
        end
        for (int b = 0; b < 2; b++)
            m_cur[b] = lvl_of(on_w(b, m_pos), on_w(1 - b, m_pos), m_mask[b], hold_i, boost_i);
    endtask

    task automatic chk(bit ok, string tag, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic compare_all();
        chk(phase_a_o == m_ph[0], "R2", "phase_a", phase_a_o, m_ph[0]);
        chk(phase_b_o == m_ph[1], "R2", "phase_b", phase_b_o, m_ph[1]);
        chk(cur_a_o == m_cur[0], "R3", "cur_a", cur_a_o, m_cur[0]);
        chk(cur_b_o == m_cur[1], "R3", "cur_b", cur_b_o, m_cur[1]);
        chk(busy_o == m_busy, "R5", "busy", busy_o, m_busy);
    endtask

    task automatic tick();
        model_edge();
        @(negedge clk);
        compare_all();
    endtask

    task automatic do_step(bit d);
        dir_i = d; step_i = 1; tick(); step_i = 0;
        while (m_busy) tick();
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL R5 watchdog actual=timeout expected=done");
        summary();
    end

    initial begin
        int busy_cnt;
        process::self().srandom(32'd7);
        model_reset();
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(phase_a_o == 1 && phase_b_o == 1, "R1", "reset phases", {phase_a_o, phase_b_o}, 3);
        chk(cur_a_o == 2'b01 && cur_b_o == 2'b01, "R1", "reset codes", {cur_a_o, cur_b_o}, 5);
        chk(busy_o == 0, "R1", "reset busy", busy_o, 0);
        rst_n = 1;
        decay_len_i = 2;
        tick();

        // R10 / R9: 0 -> 1, no reversal
        dir_i = 1; half_i = 1; step_i = 1; tick(); step_i = 0;
        chk(busy_o == 0, "R10", "busy on plain step", busy_o, 0);
        chk(cur_a_o == 2'b00 && cur_b_o == 2'b11, "R10", "codes at pos1", {cur_a_o, cur_b_o}, 3);
        chk(phase_b_o == 1, "R9", "off winding phase kept", phase_b_o, 1);

        // R5 / R6: 1 -> 2 reverses B, steps held high during interval
        step_i = 1; busy_cnt = 0;
        tick();
        chk(cur_b_o == 2'b11 && phase_b_o == 1, "R5", "B forced off, old phase", {cur_b_o, phase_b_o}, 7);
        if (busy_o) busy_cnt++;
        tick(); if (busy_o) busy_cnt++;
        tick(); if (busy_o) busy_cnt++;
        step_i = 0;
        chk(busy_cnt == 2, "R5", "busy cycles", busy_cnt, 2);
        chk(cur_a_o == 2'b01 && cur_b_o == 2'b01 && phase_b_o == 0, "R6", "landed at pos2",
            {cur_a_o, cur_b_o, phase_b_o}, 10);

        // R8: six more forward steps wrap to pos0
        for (int k = 0; k < 6; k++) do_step(1);
        chk(phase_a_o == 1 && phase_b_o == 1 && cur_a_o == 2'b01 && cur_b_o == 2'b01,
            "R8", "forward wrap to pos0", {phase_a_o, phase_b_o, cur_a_o, cur_b_o}, 53);
        do_step(0);
        chk(cur_a_o == 2'b11 && cur_b_o == 2'b00 && phase_b_o == 1, "R8", "backward wrap to pos7",
            {cur_a_o, cur_b_o, phase_b_o}, 25);

        // R7: full mode from odd position 1 forward lands on pos2
        do_step(1); do_step(1);
        half_i = 0; decay_len_i = 0;
        step_i = 1; tick(); step_i = 0;
        chk(busy_o == 1, "R5", "zero length acts as one", busy_o, 1);
        tick();
        chk(busy_o == 0 && phase_b_o == 0 && cur_a_o == 2'b01 && cur_b_o == 2'b01, "R7",
            "full step to pos2", {busy_o, phase_b_o, cur_a_o, cur_b_o}, 5);
        do_step(1);
        chk(phase_a_o == 0 && phase_b_o == 0, "R7", "full step to pos4", {phase_a_o, phase_b_o}, 0);

        // R4: hold and boost
        hold_i = 1; tick();
        chk(cur_a_o == 2'b10 && cur_b_o == 2'b10, "R4", "hold codes", {cur_a_o, cur_b_o}, 10);
        boost_i = 1; tick();
        chk(cur_a_o == 2'b00 && cur_b_o == 2'b00, "R4", "boost over hold", {cur_a_o, cur_b_o}, 0);
        hold_i = 0; boost_i = 0; tick();
        chk(cur_a_o == 2'b01 && cur_b_o == 2'b01, "R4", "back to normal", {cur_a_o, cur_b_o}, 5);

        // Random mix
        for (int k = 0; k < 3000; k++) begin
            step_i = ($urandom_range(2) == 0);
            dir_i = $urandom_range(1);
            half_i = ($urandom_range(3) != 0);
            hold_i = ($urandom_range(7) == 0);
            boost_i = ($urandom_range(7) == 0);
            decay_len_i = DLY_W'($urandom_range(3));
            tick();
        end
        summary();
    end
endmodule